// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between operand wakeup and the functional units of an out-of-order core. Instructions that are already ready come in one per cycle. Each carries a sequence number and an operation-class code. The block files each instruction into a small pool reserved for its class, so that each pool feeds one functional-unit type.

Every cycle the oldest entry of each pool becomes that pool's head. The heads are ranked against each other by age, and up to `ISSUE_W` of them are granted, oldest first, into registered issue slots. A class whose functional unit reports busy is stepped over, and younger heads from other classes take the free slots. A flush carrying a squash sequence number discards every pooled entry younger than that number.

Sequence numbers are compared by wrap-aware subtraction. An entry A is older than B when the most significant bit of (A − B), taken modulo 2^SEQ_W, is set.

Top module: `age_issue_sel`

## Requirements
- R1: After reset all issue slots are invalid, `busy_skip` is zero and `ovf_err` is low.
- R2: Slot 0 carries the oldest granted head and each higher slot carries the next oldest. A valid slot s implies that slot s−1 is valid and older.
- R3: Within one class pool, the entry with the smaller (wrap-aware) sequence number issues first, whatever the order of insertion.
- R4: At most `ISSUE_W` instructions issue per cycle, and at most one per class per cycle.
- R5: A class whose `fu_busy` bit is set issues nothing that cycle, and its entries stay pooled. Its `busy_skip` bit is set in the next cycle if it had a head. Other classes may still use the slots.
- R6: Age comparison is wrap-aware, so that sequence 250 issues before sequence 3 in an 8-bit space.
- R7: In a flush cycle, entries younger than `flush_seq` are removed, while entries equal to or older than it are kept. Nothing issues and the insert of that cycle is dropped.
- R8: An insert into a full pool (depth `POOL_DEPTH`) is dropped and sets the sticky `ovf_err` flag, even if the pool pops in the same cycle.
- R9: An entry inserted at clock edge k can first appear in a slot after edge k+1.
- R10: An issued entry leaves its pool and is never issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a ready instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_cls | input | CLS_W | Operation class (0..NUM_CLS−1) |
| fu_busy | input | NUM_CLS | Functional unit busy, one bit per class |
| flush | input | 1 | Discard entries younger than `flush_seq` |
| flush_seq | input | SEQ_W | Squash boundary sequence number |
| iss_vld | output | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence numbers, slot s at bits [s*SEQ_W +: SEQ_W] |
| iss_cls | output | ISSUE_W*CLS_W | Class codes, slot s at bits [s*CLS_W +: CLS_W] |
| busy_skip | output | NUM_CLS | Class had a head but its unit was busy |
| ovf_err | output | 1 | Sticky pool overflow flag |

## Verification
Directed patterns each isolate one selection rule:
- Out-of-order inserts into one held pool separate in-pool age order from insert order.
- Heads spread over three classes and released together show that cross-class ranking and the two-slot cut are used, rather than class index.
- A busy class between two free ones shows skipping, as opposed to stalling.
- A pair straddling the counter wrap tells wrap-aware comparison apart from plain magnitude comparison.
- A flush at a middle sequence number shows the boundary: equal entries are kept and younger ones are removed.

A long seeded random phase then mixes inserts, busy masks and occasional flushes over several counter wraps. It is checked every cycle against a model of the pools.

// File: rtl/age_issue_sel_pkg.sv
package age_issue_sel_pkg;
  // a is older than b when (a - b) is negative in the modular sequence space
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/iss_pool.sv
module iss_pool #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic             pop,
  input  logic             flush,
  input  logic [SEQ_W-1:0] flush_seq,
  output logic             head_vld,
  output logic [SEQ_W-1:0] head_seq,
  output logic             full
);
  import age_issue_sel_pkg::*;

  logic [DEPTH-1:0] vld;
  logic [SEQ_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] head_idx, free_idx;

  // oldest valid entry
  always_comb begin
    head_vld = 1'b0;
    head_seq = '0;
    head_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (!head_vld || seq_older(32'(mem[i]), 32'(head_seq), SEQ_W))) begin
        head_vld = 1'b1;
        head_seq = mem[i];
        head_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign full = &vld;

  always_ff @(posedge clk) begin
    if (wr_en && !full && !flush) mem[free_idx] <= wr_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++)
        if (vld[i] && seq_older(32'(flush_seq), 32'(mem[i]), SEQ_W)) vld[i] <= 1'b0;
    end else begin
      if (pop) vld[head_idx] <= 1'b0;
      if (wr_en && !full) vld[free_idx] <= 1'b1;
    end
  end

  // R10: a pop only ever removes an existing head
  a_r10_pop_has_head: assert property (@(posedge clk) disable iff (rst) pop |-> head_vld);
endmodule

// File: rtl/iss_age_rank.sv
module iss_age_rank #(
  parameter int NUM_CLS = 3,
  parameter int SEQ_W   = 8,
  parameter int ISSUE_W = 2,
  localparam int RK_W   = $clog2(NUM_CLS + 1)
) (
  input  logic [NUM_CLS-1:0]       elig,
  input  logic [NUM_CLS*SEQ_W-1:0] heads,
  output logic [NUM_CLS-1:0]       grant,
  output logic [NUM_CLS*RK_W-1:0]  rank
);
  import age_issue_sel_pkg::*;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [RK_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int d = 0; d < NUM_CLS; d++) begin
        if (d != c && elig[d]) begin
          if (seq_older(32'(heads[d*SEQ_W +: SEQ_W]), 32'(heads[c*SEQ_W +: SEQ_W]), SEQ_W) ||
              (heads[d*SEQ_W +: SEQ_W] == heads[c*SEQ_W +: SEQ_W] && d < c))
            cnt = cnt + 1'b1;
        end
      end
    end
    assign rank[c*RK_W +: RK_W] = cnt;
    assign grant[c] = elig[c] && (32'(cnt) < ISSUE_W);
  end

  // R4: never more grants than slots
  a_r4_grant_width: assert final ($countones(grant) <= ISSUE_W);
endmodule

// File: rtl/age_issue_sel.sv
module age_issue_sel #(
  parameter int NUM_CLS    = 3,
  parameter int POOL_DEPTH = 4,
  parameter int SEQ_W      = 8,
  parameter int ISSUE_W    = 2,
  localparam int CLS_W     = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic [CLS_W-1:0]         ins_cls,
  input  logic [NUM_CLS-1:0]       fu_busy,
  input  logic                     flush,
  input  logic [SEQ_W-1:0]         flush_seq,
  output logic [ISSUE_W-1:0]       iss_vld,
  output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  output logic [ISSUE_W*CLS_W-1:0] iss_cls,
  output logic [NUM_CLS-1:0]       busy_skip,
  output logic                     ovf_err
);
  import age_issue_sel_pkg::*;
  localparam int RK_W = $clog2(NUM_CLS + 1);

  logic [NUM_CLS-1:0]       head_vld, full, elig, grant;
  logic [NUM_CLS*SEQ_W-1:0] heads;
  logic [NUM_CLS*RK_W-1:0]  rank;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_pool
    iss_pool #(.DEPTH(POOL_DEPTH), .SEQ_W(SEQ_W)) u_pool (
      .clk(clk), .rst(rst),
      .wr_en(ins_valid && (32'(ins_cls) == c)),
      .wr_seq(ins_seq),
      .pop(grant[c]),
      .flush(flush), .flush_seq(flush_seq),
      .head_vld(head_vld[c]),
      .head_seq(heads[c*SEQ_W +: SEQ_W]),
      .full(full[c])
    );
  end

  assign elig = head_vld & ~fu_busy & {NUM_CLS{!flush}};

  iss_age_rank #(.NUM_CLS(NUM_CLS), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W)) u_rank (
    .elig(elig), .heads(heads), .grant(grant), .rank(rank)
  );

  logic [ISSUE_W-1:0]       n_vld;
  logic [ISSUE_W*SEQ_W-1:0] n_seq;
  logic [ISSUE_W*CLS_W-1:0] n_cls;

  always_comb begin
    n_vld = '0;
    n_seq = '0;
    n_cls = '0;
    for (int s = 0; s < ISSUE_W; s++)
      for (int c = 0; c < NUM_CLS; c++)
        if (grant[c] && rank[c*RK_W +: RK_W] == RK_W'(s)) begin
          n_vld[s] = 1'b1;
          n_seq[s*SEQ_W +: SEQ_W] = heads[c*SEQ_W +: SEQ_W];
          n_cls[s*CLS_W +: CLS_W] = CLS_W'(c);
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld   <= '0;
      iss_seq   <= '0;
      iss_cls   <= '0;
      busy_skip <= '0;
      ovf_err   <= 1'b0;
    end else begin
      iss_vld   <= n_vld;
      iss_seq   <= n_seq;
      iss_cls   <= n_cls;
      busy_skip <= head_vld & fu_busy & {NUM_CLS{!flush}};
      if (ins_valid && !flush && (32'(ins_cls) < NUM_CLS) && full[ins_cls]) ovf_err <= 1'b1;
    end
  end

  // decode of the output slots per class, used by the checks below
  logic [NUM_CLS-1:0] cls_hit;
  always_comb begin
    cls_hit = '0;
    for (int s = 0; s < ISSUE_W; s++)
      if (iss_vld[s] && 32'(iss_cls[s*CLS_W +: CLS_W]) < NUM_CLS)
        cls_hit[iss_cls[s*CLS_W +: CLS_W]] = 1'b1;
  end

  // R7: a flush cycle produces no issue
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (rst) flush |=> iss_vld == '0);
  // R8: insert into a full pool raises the error flag
  a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !flush && (32'(ins_cls) < NUM_CLS) && full[ins_cls]) |=> ovf_err);
  // R4: slots carry distinct classes
  a_r4_one_per_class: assert property (@(posedge clk) disable iff (rst)
    $countones(cls_hit) == $countones(iss_vld));

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_chk
    // R5: a busy class never appears in the following slots
    a_r5_busy_skipped: assert property (@(posedge clk) disable iff (rst) fu_busy[c] |=> !cls_hit[c]);
  end

  for (genvar s = 1; s < ISSUE_W; s++) begin : g_ord
    // R2: slots fill from 0 and age increases with the slot index
    a_r2_slot_order: assert property (@(posedge clk) disable iff (rst)
      iss_vld[s] |-> (iss_vld[s-1] &&
        seq_older(32'(iss_seq[(s-1)*SEQ_W +: SEQ_W]), 32'(iss_seq[s*SEQ_W +: SEQ_W]), SEQ_W)));
  end
endmodule

// File: tb/test_age_issue_sel.sv
module test_age_issue_sel;
  localparam int NC = 3, DP = 4, SW = 8, IW = 2, CW = 2;

  logic clk = 0, rst = 1;
  logic ins_valid = 0;
  logic [SW-1:0] ins_seq = 0;
  logic [CW-1:0] ins_cls = 0;
  logic [NC-1:0] fu_busy = 0;
  logic flush = 0;
  logic [SW-1:0] flush_seq = 0;
  logic [IW-1:0] iss_vld;
  logic [IW*SW-1:0] iss_seq;
  logic [IW*CW-1:0] iss_cls;
  logic [NC-1:0] busy_skip;
  logic ovf_err;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  age_issue_sel #(.NUM_CLS(NC), .POOL_DEPTH(DP), .SEQ_W(SW), .ISSUE_W(IW)) i_age_issue_sel (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_cls(ins_cls),
    .fu_busy(fu_busy), .flush(flush), .flush_seq(flush_seq),
    .iss_vld(iss_vld), .iss_seq(iss_seq), .iss_cls(iss_cls),
    .busy_skip(busy_skip), .ovf_err(ovf_err));

  // model of the pools
  logic mv [NC][DP];
  logic [SW-1:0] ms [NC][DP];
  logic m_ovf;

  function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit iv, input logic [SW-1:0] is, input int ic,
                     input logic [NC-1:0] bz, input bit fl, input logic [SW-1:0] fs, input string tag);
    logic hv [NC];
    logic [SW-1:0] hs [NC];
    int hi [NC];
    logic el [NC];
    logic gr [NC];
    int rk [NC];
    logic e_v [IW];
    logic [SW-1:0] e_s [IW];
    int e_c [IW];
    logic [NC-1:0] e_bs;
    int cnt_pre;
    ins_valid = iv; ins_seq = is; ins_cls = CW'(ic); fu_busy = bz; flush = fl; flush_seq = fs;
    for (int c = 0; c < NC; c++) begin
      hv[c] = 0; hs[c] = 0; hi[c] = 0;
      for (int i = 0; i < DP; i++)
        if (mv[c][i] && (!hv[c] || older(ms[c][i], hs[c]))) begin hv[c] = 1; hs[c] = ms[c][i]; hi[c] = i; end
      el[c] = hv[c] && !bz[c] && !fl;
      e_bs[c] = hv[c] && bz[c] && !fl;
    end
    for (int s = 0; s < IW; s++) begin e_v[s] = 0; e_s[s] = 0; e_c[s] = 0; end
    for (int c = 0; c < NC; c++) begin
      rk[c] = 0;
      for (int d = 0; d < NC; d++)
        if (d != c && el[d] && (older(hs[d], hs[c]) || (hs[d] == hs[c] && d < c))) rk[c]++;
      gr[c] = el[c] && rk[c] < IW;
      if (gr[c]) begin e_v[rk[c]] = 1; e_s[rk[c]] = hs[c]; e_c[rk[c]] = c; end
    end
    @(posedge clk);
    if (fl) begin
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < DP; i++)
          if (mv[c][i] && older(fs, ms[c][i])) mv[c][i] = 0;
    end else begin
      cnt_pre = 0;
      if (iv) for (int i = 0; i < DP; i++) if (mv[ic][i]) cnt_pre++;
      for (int c = 0; c < NC; c++) if (gr[c]) mv[c][hi[c]] = 0;
      if (iv) begin
        if (cnt_pre == DP) m_ovf = 1;
        else begin
          for (int i = 0; i < DP; i++)
            if (!mv[ic][i]) begin mv[ic][i] = 1; ms[ic][i] = is; break; end
        end
      end
    end
    @(negedge clk);
    for (int s = 0; s < IW; s++) begin
      chk(tag, 32'(iss_vld[s]), 32'(e_v[s]), $sformatf("slot%0d valid", s));
      if (e_v[s]) begin
        chk(tag, 32'(iss_seq[s*SW +: SW]), 32'(e_s[s]), $sformatf("slot%0d seq", s));
        chk(tag, 32'(iss_cls[s*CW +: CW]), 32'(e_c[s]), $sformatf("slot%0d class", s));
      end
    end
    chk(tag, 32'(busy_skip), 32'(e_bs), "busy_skip");
    chk(tag, 32'(ovf_err), 32'(m_ovf), "ovf_err");
  endtask

  task automatic idle(input logic [NC-1:0] bz, input string tag);
    cyc(0, 0, 0, bz, 0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [SW-1:0] nseq;
    for (int c = 0; c < NC; c++) for (int i = 0; i < DP; i++) begin mv[c][i] = 0; ms[c][i] = 0; end
    m_ovf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1", 32'(iss_vld), 0, "valid after reset");
    chk("R1", 32'(busy_skip), 0, "busy_skip after reset");
    chk("R1", 32'(ovf_err), 0, "ovf after reset");
    // R3 in-pool order independent of insert order
    cyc(1, 10, 0, 3'b001, 0, 0, "R3");
    cyc(1, 5,  0, 3'b001, 0, 0, "R3");
    cyc(1, 7,  0, 3'b001, 0, 0, "R3");
    idle(3'b001, "R5");
    repeat (4) idle(3'b000, "R3");
    // R2/R4 cross-class ranking and slot limit
    cyc(1, 20, 0, 3'b111, 0, 0, "R2");
    cyc(1, 18, 1, 3'b111, 0, 0, "R2");
    cyc(1, 19, 2, 3'b111, 0, 0, "R2");
    idle(3'b000, "R4");
    idle(3'b000, "R10");
    idle(3'b000, "R10");
    // R5 busy class skipped, others proceed
    cyc(1, 30, 1, 3'b010, 0, 0, "R5");
    cyc(1, 31, 0, 3'b010, 0, 0, "R5");
    cyc(1, 32, 2, 3'b010, 0, 0, "R5");
    idle(3'b010, "R5");
    idle(3'b000, "R5");
    // R6 wrap-aware age
    cyc(1, 3,   1, 3'b111, 0, 0, "R6");
    cyc(1, 250, 0, 3'b111, 0, 0, "R6");
    idle(3'b000, "R6");
    idle(3'b000, "R6");
    // R7 flush boundary; insert during flush dropped
    cyc(1, 40, 0, 3'b111, 0, 0, "R7");
    cyc(1, 41, 1, 3'b111, 0, 0, "R7");
    cyc(1, 42, 2, 3'b111, 0, 0, "R7");
    cyc(1, 43, 2, 3'b000, 1, 41, "R7");
    idle(3'b000, "R7");
    idle(3'b000, "R7");
    // R9 latency
    cyc(1, 50, 2, 3'b000, 0, 0, "R9");
    idle(3'b000, "R9");
    idle(3'b000, "R9");
    // random phase
    nseq = 60;
    for (int n = 0; n < 1500; n++) begin
      bit iv, fl;
      int ic;
      logic [NC-1:0] bz;
      iv = ($urandom % 4) != 0;
      ic = $urandom % NC;
      bz = NC'($urandom) & NC'($urandom);
      fl = ($urandom % 40) == 0;
      cyc(iv, nseq, ic, bz, fl, nseq - SW'($urandom % 6), fl ? "R7" : "R2");
      if (iv) nseq = nseq + 1;
    end
    cyc(0, 0, 0, 3'b000, 1, nseq - 8'd128, "R7");
    idle(3'b000, "R10");
    // R8 overflow: fill class 0, insert one more while popping
    for (int i = 0; i < DP; i++) cyc(1, 8'(100 + i), 0, 3'b001, 0, 0, "R8");
    cyc(1, 104, 0, 3'b000, 0, 0, "R8");
    repeat (DP + 1) idle(3'b000, "R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule